// File: doc/BRIEF.md
# Pulse-Driven DAC Code Counter

This block holds the 8-bit code of a current-output converter and lets a host adjust it with single pulses instead of whole serial words. A pulse is a rising edge on the step input, sampled in the system clock domain. Each pulse moves the upper six code bits by one, so the code moves in steps of four LSBs, and the two low bits stay as they are.

How the pulses are interpreted is settled by two latches that record input levels after reset and never clear until the next reset. While the chip-select level stays high, the block is in pulse mode. Once it is seen low, the block belongs to the serial port for good, and that port writes the whole code in parallel. Within pulse mode, the data line starts out meaning "count up only", and the code wraps from full scale to zero. The first low level seen on the data line turns it into a direction control for good. In that mode the code stops at full scale and at zero instead of wrapping.

A low on the sleep input freezes the stored code: pulses and serial writes are dropped while it is low. The mode latches keep tracking their inputs during sleep.

Top module: `pulse_code_counter`

## Requirements
- R1: While reset is low and after its release, before any other event: `code` = 8'h80, `serial_mode` = 0, `updown_mode` = 0.
- R2: A low `sel_n` at any clock edge sets `serial_mode` to 1, and it stays 1 until reset. While `serial_mode` = 1 or `sel_n` = 0, step pulses leave `code` unchanged.
- R3: A low `dir_in` at a clock edge in pulse mode (`serial_mode` = 0 and `sel_n` = 1) sets `updown_mode` to 1, and it stays 1 until reset. A low `dir_in` in serial mode does not set it.
- R4: A step is a clock edge at which `step_in` = 1 after it was 0 at the previous edge; a level held high counts once. A step changes `code[7:2]` by one at that same edge and leaves `code[1:0]` unchanged.
- R5: In count-up-only mode (`updown_mode` = 0 and `dir_in` = 1), each step adds one to `code[7:2]` modulo 64, so 8'hFC goes to 8'h00.
- R6: In up/down mode, `dir_in` = 1 at the step edge counts up and `dir_in` = 0 counts down. A step taken with the first low `dir_in` already counts down.
- R7: In up/down mode, an up step at `code[7:2]` = 63 and a down step at `code[7:2]` = 0 leave the code unchanged.
- R8: While `sleep_n` = 0, `code` holds its value: steps and writes are ignored.
- R9: In serial mode with `sleep_n` = 1, `wr_en` = 1 at a clock edge loads all 8 bits of `wr_code` into `code` at that edge. In pulse mode, `wr_en` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip-select level; low makes the mode serial for good |
| dir_in | input | 1 | Data line; in pulse mode, selects the count mode and the direction |
| step_in | input | 1 | Pulse input; each rising edge is one step |
| sleep_n | input | 1 | Low freezes the stored code |
| wr_en | input | 1 | Serial-side parallel write strobe |
| wr_code | input | 8 | Code loaded by a serial-side write |
| code | output | 8 | Current converter code |
| serial_mode | output | 1 | Latched serial-mode flag |
| updown_mode | output | 1 | Latched up/down-mode flag |

## Verification
Every result here is due at the first clock edge that samples the stimulus. A step edge updates the code, and a low select or data level sets its flag, with no extra register in between. The bench changes inputs on the falling edge and reads outputs on the next falling edge, one edge after the change. Each pulse is then released for a full cycle before the next one, so every counted step is a fresh rising edge. Ignored steps, sleep and dropped writes are checked by reading the code again after the same single edge.

// File: rtl/pcc_pkg.sv
// Shared types for the pulse-driven code counter.
package pcc_pkg;
    // Effective interpretation of the pulse and write inputs in one cycle.
    typedef enum logic [1:0] {
        PCC_INC_ONLY = 2'd0,
        PCC_UPDOWN   = 2'd1,
        PCC_SERIAL   = 2'd2
    } pcc_mode_t;
endpackage

// File: rtl/pcc_mode_latch.sv
// Sticky mode latches. Records a low select level (serial ownership) and,
// in pulse mode only, a low data level (up/down counting). Both clear only
// on reset. Also gives the effective mode for the current edge, so a level
// acts in the same cycle it is first seen.
// Assumes sel_n and dir_in are already synchronous to clk.
module pcc_mode_latch (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n,
    input  logic                dir_in,
    output logic                serial_q,
    output logic                updown_q,
    output pcc_pkg::pcc_mode_t  mode
);
    // Sticky capture of both levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serial_q <= 1'b0;
            updown_q <= 1'b0;
        end else begin
            if (!sel_n)
                serial_q <= 1'b1;
            if (!dir_in && sel_n && !serial_q)
                updown_q <= 1'b1;
        end
    end

    // Mode in force at this edge: latched state merged with live levels.
    always_comb begin
        if (serial_q || !sel_n)
            mode = pcc_pkg::PCC_SERIAL;
        else if (updown_q || !dir_in)
            mode = pcc_pkg::PCC_UPDOWN;
        else
            mode = pcc_pkg::PCC_INC_ONLY;
    end
endmodule

// File: rtl/pcc_rise_detect.sv
// Rising-edge detector for the pulse input. The stored previous level
// resets to 1, so a level that is already high when reset ends is not
// counted. Assumes the input is synchronous to clk.
module pcc_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_q;

    // Remember the level sampled at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b1;
        else
            prev_q <= level;
    end

    // High for the cycle in which the level first goes high.
    assign rise = level & ~prev_q;
endmodule

// File: rtl/pcc_step_next.sv
// Next value of the stepped upper field for one pulse. Wraps in
// count-up-only mode and saturates at both ends in up/down mode. Pure logic.
module pcc_step_next #(
    parameter int unsigned UW = 6
) (
    input  logic [UW-1:0]       cur,
    input  pcc_pkg::pcc_mode_t  mode,
    input  logic                dir_up,
    output logic [UW-1:0]       nxt
);
    localparam logic [UW-1:0] TOP = {UW{1'b1}};
    localparam logic [UW-1:0] ONE = UW'(1);

    // Select wrap, saturating up, saturating down or hold.
    always_comb begin
        unique case (mode)
            pcc_pkg::PCC_INC_ONLY: nxt = cur + ONE;
            pcc_pkg::PCC_UPDOWN: begin
                if (dir_up)
                    nxt = (cur == TOP) ? cur : cur + ONE;
                else
                    nxt = (cur == '0) ? cur : cur - ONE;
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/pulse_code_counter.sv
// Top of the pulse-driven DAC code counter. Owns the code register that is
// shared by the pulse path and the serial-side parallel write. Pulses step
// only bits [CODE_W-1:STEP_LSB]; the low bits change only by a write.
// Sleep freezes the code. Assumes all inputs are synchronous to clk.
module pulse_code_counter #(
    parameter int unsigned       CODE_W     = 8,
    parameter int unsigned       STEP_LSB   = 2,
    parameter logic [CODE_W-1:0] RESET_CODE = {1'b1, {(CODE_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              dir_in,
    input  logic              step_in,
    input  logic              sleep_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-1:0] code,
    output logic              serial_mode,
    output logic              updown_mode
);
    localparam int unsigned UW = CODE_W - STEP_LSB;

    pcc_pkg::pcc_mode_t mode;
    logic               step_rise;
    logic [UW-1:0]      upper_nxt;
    logic [CODE_W-1:0]  code_q;

    pcc_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .dir_in   (dir_in),
        .serial_q (serial_mode),
        .updown_q (updown_mode),
        .mode     (mode)
    );

    pcc_rise_detect u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (step_in),
        .rise  (step_rise)
    );

    pcc_step_next #(.UW(UW)) u_next (
        .cur    (code_q[CODE_W-1:STEP_LSB]),
        .mode   (mode),
        .dir_up (dir_in),
        .nxt    (upper_nxt)
    );

    // Code register: serial write, or one pulse step, unless asleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= RESET_CODE;
        end else if (sleep_n) begin
            if (mode == pcc_pkg::PCC_SERIAL) begin
                if (wr_en)
                    code_q <= wr_code;
            end else if (step_rise) begin
                code_q[CODE_W-1:STEP_LSB] <= upper_nxt;
            end
        end
    end

    assign code = code_q;
endmodule

// File: rtl/pcc_checker.sv
// Temporal checks for pulse_code_counter, attached by bind. Reads ports only.
module pcc_checker #(
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned STEP_LSB = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              sleep_n,
    input logic [CODE_W-1:0] code,
    input logic              serial_mode,
    input logic              updown_mode
);
    localparam int unsigned     UW  = CODE_W - STEP_LSB;
    localparam logic [UW-1:0]   TOP = {UW{1'b1}};
    localparam logic [UW-1:0]   ONE = UW'(1);

    // R2: serial ownership is sticky.
    assert_serial_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |=> serial_mode);

    // R3: up/down selection is sticky.
    assert_updown_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        updown_mode |=> updown_mode);

    // R4: in pulse mode the low bits never move and the upper field moves by at most one.
    assert_low_bits_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && sel_n) |=> $stable(code[STEP_LSB-1:0]));
    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && sel_n) |=>
            (code[CODE_W-1:STEP_LSB] == $past(code[CODE_W-1:STEP_LSB])) ||
            (code[CODE_W-1:STEP_LSB] == $past(code[CODE_W-1:STEP_LSB]) + ONE) ||
            (code[CODE_W-1:STEP_LSB] == $past(code[CODE_W-1:STEP_LSB]) - ONE));

    // R7: no wrap at either end in up/down mode.
    assert_no_wrap_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (updown_mode && sel_n && !serial_mode && code[CODE_W-1:STEP_LSB] == TOP)
            |=> code[CODE_W-1:STEP_LSB] != '0);
    assert_no_wrap_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (updown_mode && sel_n && !serial_mode && code[CODE_W-1:STEP_LSB] == '0)
            |=> code[CODE_W-1:STEP_LSB] != TOP);

    // R8: sleep freezes the code.
    assert_sleep_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> $stable(code));
endmodule

bind pulse_code_counter pcc_checker #(
    .CODE_W   (CODE_W),
    .STEP_LSB (STEP_LSB)
) u_pcc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_n       (sel_n),
    .sleep_n     (sleep_n),
    .code        (code),
    .serial_mode (serial_mode),
    .updown_mode (updown_mode)
);

// File: tb/pulse_code_counter_test.sv
// Sweep bench: drives on falling edges, reads on the next falling edge.
module pulse_code_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       dir_in = 1'b1;
    logic       step_in = 1'b0;
    logic       sleep_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_code = 8'h00;
    logic [7:0] code;
    logic       serial_mode;
    logic       updown_mode;

    int checks = 0;
    int errors = 0;
    int up = 32;          // expected upper field
    bit done = 1'b0;

    always #4 clk = ~clk;

    pulse_code_counter uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dir_in(dir_in),
        .step_in(step_in), .sleep_n(sleep_n), .wr_en(wr_en), .wr_code(wr_code),
        .code(code), .serial_mode(serial_mode), .updown_mode(updown_mode)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One fresh pulse; the code is read one edge after the rise.
    task automatic pulse();
        step_in = 1'b1;
        tick();
    endtask

    task automatic release_step();
        step_in = 1'b0;
        tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sel_n = 1'b1; dir_in = 1'b1; step_in = 1'b0; sleep_n = 1'b1; wr_en = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        up = 32;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 code", code, 8'h80);
        check("R1 serial_mode", {7'b0, serial_mode}, 8'h00);
        check("R1 updown_mode", {7'b0, updown_mode}, 8'h00);

        // R9 write ignored in pulse mode
        wr_code = 8'h33; wr_en = 1'b1; tick(); wr_en = 1'b0;
        check("R9 write ignored in pulse mode", code, 8'h80);

        // R4/R5 count-up-only sweep with wrap
        for (int i = 0; i < 70; i++) begin
            pulse();
            up = (up + 1) % 64;
            check(up == 0 ? "R5 wrap to zero" : "R4 step up", code, 8'(up * 4));
            release_step();
        end
        check("R3 flag still clear", {7'b0, updown_mode}, 8'h00);

        // R4 held level counts once
        step_in = 1'b1; tick();
        up = (up + 1) % 64;
        check("R4 first edge of held level", code, 8'(up * 4));
        tick(); tick();
        check("R4 held level counts once", code, 8'(up * 4));
        release_step();

        // R3/R6 first low data level counts down on the same edge
        dir_in = 1'b0; pulse();
        up = (up > 0) ? up - 1 : 0;
        check("R6 first low counts down", code, 8'(up * 4));
        check("R3 updown latched", {7'b0, updown_mode}, 8'h01);
        release_step();
        dir_in = 1'b1; pulse();
        up = (up < 63) ? up + 1 : 63;
        check("R6 high counts up", code, 8'(up * 4));
        release_step();

        // R7 down sweep past zero
        dir_in = 1'b0;
        for (int i = 0; i < 70; i++) begin
            pulse();
            up = (up > 0) ? up - 1 : 0;
            check(up == 0 ? "R7 hold at zero" : "R6 step down", code, 8'(up * 4));
            release_step();
        end
        // R7 up sweep past full scale
        dir_in = 1'b1;
        for (int i = 0; i < 70; i++) begin
            pulse();
            up = (up < 63) ? up + 1 : 63;
            check(up == 63 ? "R7 hold at full scale" : "R6 step up", code, 8'(up * 4));
            release_step();
        end
        check("R3 updown sticky", {7'b0, updown_mode}, 8'h01);

        // R8 sleep ignores pulses
        sleep_n = 1'b0;
        dir_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            pulse();
            check("R8 pulse ignored in sleep", code, 8'(up * 4));
            release_step();
        end
        sleep_n = 1'b1; dir_in = 1'b1;

        // R2 serial mode
        do_reset();
        check("R1 code after second reset", code, 8'h80);
        check("R1 updown cleared", {7'b0, updown_mode}, 8'h00);
        sel_n = 1'b0; tick(); sel_n = 1'b1;
        check("R2 serial latched", {7'b0, serial_mode}, 8'h01);
        pulse();
        check("R2 pulse ignored in serial", code, 8'h80);
        release_step();
        dir_in = 1'b0; tick(); dir_in = 1'b1;
        check("R3 not set in serial", {7'b0, updown_mode}, 8'h00);

        // R9 write
        wr_code = 8'h5B; wr_en = 1'b1; tick(); wr_en = 1'b0;
        check("R9 serial write", code, 8'h5B);
        check("R2 serial sticky", {7'b0, serial_mode}, 8'h01);
        sleep_n = 1'b0; wr_code = 8'h11; wr_en = 1'b1; tick(); wr_en = 1'b0;
        check("R8 write ignored in sleep", code, 8'h5B);
        sleep_n = 1'b1;
        pulse();
        check("R2 pulse still ignored", code, 8'h5B);
        release_step();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule